// File: doc/BRIEF.md
# Boundary-Scan Shift Engine with Masked Compare

This block drives the clock, mode-select and serial-data lines of a boundary-scan chain and samples the chain's serial output. A sequencer starts it with a chain length and a mode. It then clocks a full test vector into the selected chain. In compare mode it checks the bits that come out of the chain against expected values, but only at the cells that a mask selects. Any checked cell that does not match raises a sticky mismatch flag. The sequencer copies that flag into whichever error flag it has selected.

Operands arrive over a ready/valid handshake as one group of three bytes per eight cells: the vector byte, the expected byte and the mask byte. The first group covers the eight cells nearest the output end of the chain. Within a group, bit 0 is shifted first, so bit 7 of the first group lands on the lowest cell of the top eight. The scan clock is the system clock divided by two and runs only while bits are moving. Data and mode-select change on its falling edge, and the chain output is sampled on its rising edge. Moving the TAP to the shift state beforehand, reset pulses and free-running clock bursts belong to the sequencer.

Top module: `scan_shift_engine`

## Requirements
- R1: After reset, tck_o, tms_o, busy_o, done_o, err_o, mismatch_o and opnd_ready_o are all 0.
- R2: A start_i seen while idle begins a shift of len_m1_i+1 cells (1 to MAX_CELLS), and exactly that many rising edges appear on tck_o.
- R3: tms_o is 0 at every rising edge of tck_o in a shift except the last one, where it is 1.
- R4: Stream bit i (0 is first) equals bit i mod 8 of the vector byte of group i/8. After the shift it rests in cell len-1-i, where cell 0 is at the data-in end of the chain. tdi_o changes only while tck_o is low.
- R5: One operand group is taken per 8 cells, ceil(len/8) groups in all, each on a cycle with opnd_ready_o and opnd_valid_i both high. opnd_ready_o is high only while tck_o is low, and tck_o holds low until the group arrives.
- R6: In compare mode (cmp_en_i=1 at start), mismatch_o becomes 1 exactly when some stream bit i has mask bit 1 and the value sampled from tdo_i differs from the expected bit. Bit i uses the same group and bit indexing as in R4. Mask bit 0 makes the cell a don't-care.
- R7: In ignore mode (cmp_en_i=0 at start), mismatch_o stays 0 whatever the chain returns.
- R8: done_o pulses for one cycle after the last falling edge of tck_o, and busy_o is 0 on the next cycle. err_o pulses with done_o when the shift found a mismatch.
- R9: mismatch_o keeps its value after the shift ends. It is cleared on the cycle after the next accepted start.
- R10: A start_i while busy_o is 1 is ignored: the running shift keeps its length and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a shift (taken only when idle) |
| cmp_en_i | input | 1 | 1 = compare mode, 0 = ignore mode |
| len_m1_i | input | LEN_W | Chain length minus one |
| opnd_valid_i | input | 1 | Operand group valid |
| opnd_ready_o | output | 1 | Engine can take an operand group |
| opnd_new_i | input | GRP_W | Vector byte |
| opnd_exp_i | input | GRP_W | Expected capture byte |
| opnd_mask_i | input | GRP_W | Compare mask byte (1 = check) |
| tck_o | output | 1 | Scan clock |
| tms_o | output | 1 | Mode select |
| tdi_o | output | 1 | Serial data into the chain |
| tdo_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Shift in progress |
| done_o | output | 1 | One-cycle end-of-shift pulse |
| err_o | output | 1 | Set-error strobe, with done_o |
| mismatch_o | output | 1 | Sticky mismatch result |

## Verification
The bench builds the engine with MAX_CELLS = 32 (a 5-bit length) and 8-bit groups. That makes a full sweep of every chain length, in both modes, short enough to run. The sweep covers lengths that end in a partial group, one to four operand fetches, and a final bit that falls at every position within a group. The bench also adds random stalls before operands and ignored starts in mid-shift. Expected cell contents and mismatch outcomes are computed from the stream-to-cell mapping over a behavioural chain model.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_FETCH = 2'd1,
    SC_SHIFT = 2'd2,
    SC_DONE  = 2'd3
  } scan_state_e;

  // position inside a group is the final one of that group
  function automatic logic is_group_end(input int pos, input int grp);
    return (pos == grp - 1);
  endfunction

  // current stream bit is the final bit of the whole shift
  function automatic logic is_stream_end(input int cnt, input int len_m1);
    return (cnt == len_m1);
  endfunction

  // number of operand groups a chain of the given length consumes
  function automatic int groups_needed(input int cells, input int grp);
    return (cells + grp - 1) / grp;
  endfunction

endpackage

// File: rtl/scan_tck_gen.sv
module scan_tck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tck_o,
  output logic rise_ev_o,
  output logic fall_ev_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tck_o <= 1'b0;
    else if (run_i) tck_o <= ~tck_o;
    else            tck_o <= 1'b0;
  end

  // rising edge happens at the coming clock edge when running with tck low
  assign rise_ev_o = run_i & ~tck_o;
  assign fall_ev_o = run_i &  tck_o;

endmodule

// File: rtl/scan_operand_unit.sv
module scan_operand_unit #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             cmp_en_i,
  input  logic [GRP_W-1:0] new_i,
  input  logic [GRP_W-1:0] exp_i,
  input  logic [GRP_W-1:0] mask_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             tdo_i,
  output logic             tdi_o,
  output logic             mismatch_o
);

  logic [GRP_W-1:0] new_sr;
  logic [GRP_W-1:0] exp_sr;
  logic [GRP_W-1:0] mask_sr;
  logic             miss_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_sr  <= '0;
      exp_sr  <= '0;
      mask_sr <= '0;
    end else if (load_i) begin
      new_sr  <= new_i;
      exp_sr  <= exp_i;
      mask_sr <= mask_i;
    end else if (shift_i) begin
      new_sr  <= new_sr  >> 1;
      exp_sr  <= exp_sr  >> 1;
      mask_sr <= mask_sr >> 1;
    end
  end

  assign tdi_o = new_sr[0];

  // compare the bit sampled at the rising edge against its expected value
  assign miss_ev = sample_i & cmp_en_i & mask_sr[0] & (tdo_i != exp_sr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mismatch_o <= 1'b0;
    else if (clear_i) mismatch_o <= 1'b0;
    else if (miss_ev) mismatch_o <= 1'b1;
  end

  // R9
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_o && !clear_i) |=> mismatch_o);

  // R4
  shift_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_en_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             opnd_valid_i,
  input  logic             fall_ev_i,
  output logic             run_o,
  output logic             opnd_ready_o,
  output logic             load_o,
  output logic             clear_o,
  output logic             cmp_q_o,
  output logic             tms_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int SUB_W = (GRP_W > 1) ? $clog2(GRP_W) : 1;

  scan_state_e      state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic             last_bit;
  logic             grp_end;
  logic             accept;

  assign last_bit = is_stream_end(int'(cnt), int'(len_q));
  assign grp_end  = is_group_end(int'(sub), GRP_W);
  assign accept   = (state == SC_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SC_IDLE;
      len_q   <= '0;
      cnt     <= '0;
      sub     <= '0;
      cmp_q_o <= 1'b0;
    end else begin
      case (state)
        SC_IDLE: begin
          if (start_i) begin
            len_q   <= len_m1_i;
            cmp_q_o <= cmp_en_i;
            cnt     <= '0;
            sub     <= '0;
            state   <= SC_FETCH;
          end
        end
        SC_FETCH: begin
          if (opnd_valid_i) state <= SC_SHIFT;
        end
        SC_SHIFT: begin
          if (fall_ev_i) begin
            if (last_bit) begin
              state <= SC_DONE;
            end else begin
              cnt <= cnt + 1'b1;
              if (grp_end) begin
                sub   <= '0;
                state <= SC_FETCH;
              end else begin
                sub <= sub + 1'b1;
              end
            end
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign run_o        = (state == SC_SHIFT);
  assign opnd_ready_o = (state == SC_FETCH);
  assign load_o       = (state == SC_FETCH) && opnd_valid_i;
  assign clear_o      = accept;
  assign tms_o        = ((state == SC_FETCH) || (state == SC_SHIFT)) && last_bit;
  assign busy_o       = (state != SC_IDLE);
  assign done_o       = (state == SC_DONE);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(len_q) && $stable(cmp_q_o)));

  // R5
  fetch_leads_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> opnd_ready_o);

endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine #(
  parameter int MAX_CELLS = 256,
  parameter int GRP_W     = 8,
  parameter int LEN_W     = $clog2(MAX_CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_en_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             opnd_valid_i,
  output logic             opnd_ready_o,
  input  logic [GRP_W-1:0] opnd_new_i,
  input  logic [GRP_W-1:0] opnd_exp_i,
  input  logic [GRP_W-1:0] opnd_mask_i,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  input  logic             tdo_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             mismatch_o
);

  logic run;
  logic tck_rise;
  logic tck_fall;
  logic opnd_load;
  logic res_clear;
  logic cmp_q;

  scan_seq_ctrl #(
    .LEN_W (LEN_W),
    .GRP_W (GRP_W)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmp_en_i     (cmp_en_i),
    .len_m1_i     (len_m1_i),
    .opnd_valid_i (opnd_valid_i),
    .fall_ev_i    (tck_fall),
    .run_o        (run),
    .opnd_ready_o (opnd_ready_o),
    .load_o       (opnd_load),
    .clear_o      (res_clear),
    .cmp_q_o      (cmp_q),
    .tms_o        (tms_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  scan_tck_gen tck_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .tck_o     (tck_o),
    .rise_ev_o (tck_rise),
    .fall_ev_o (tck_fall)
  );

  scan_operand_unit #(
    .GRP_W (GRP_W)
  ) opnd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (opnd_load),
    .clear_i    (res_clear),
    .cmp_en_i   (cmp_q),
    .new_i      (opnd_new_i),
    .exp_i      (opnd_exp_i),
    .mask_i     (opnd_mask_i),
    .shift_i    (tck_fall),
    .sample_i   (tck_rise),
    .tdo_i      (tdo_i),
    .tdi_o      (tdi_o),
    .mismatch_o (mismatch_o)
  );

  assign err_o = done_o & mismatch_o;

  // R1
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tck_o && !tms_o && !opnd_ready_o));

  // R3
  tms_final_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && tms_o) |=> ##1 done_o);

  // R4
  tdi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tck_o |-> $stable(tdi_o));

  // R5
  ready_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_ready_o |-> !tck_o);

  // R7
  ignore_mode_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cmp_q) |-> !mismatch_o);

endmodule

// File: tb/scan_shift_engine_tb_top.sv
module scan_shift_engine_tb_top;

  localparam int MAXC = 32;
  localparam int LW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_en_i = 1'b0;
  logic [LW-1:0] len_m1_i = '0;
  logic          opnd_valid_i = 1'b0;
  logic          opnd_ready_o;
  logic [7:0]    opnd_new_i = '0;
  logic [7:0]    opnd_exp_i = '0;
  logic [7:0]    opnd_mask_i = '0;
  logic          tck_o, tms_o, tdi_o;
  logic          tdo_i;
  logic          busy_o, done_o, err_o, mismatch_o;

  always #10 clk = ~clk;

  scan_shift_engine #(.MAX_CELLS(MAXC), .GRP_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_en_i(cmp_en_i),
    .len_m1_i(len_m1_i), .opnd_valid_i(opnd_valid_i), .opnd_ready_o(opnd_ready_o),
    .opnd_new_i(opnd_new_i), .opnd_exp_i(opnd_exp_i), .opnd_mask_i(opnd_mask_i),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .mismatch_o(mismatch_o)
  );

  int pass_cnt = 0;
  int fail_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // chain model: bits entering at tck rises, capture presented on tdo per fall
  int          rise_total = 0;
  int          fall_total = 0;
  logic [63:0] tin_h = '0;
  logic [63:0] tms_h = '0;
  always @(posedge tck_o) begin
    rise_total++;
    tin_h = {tin_h[62:0], tdi_o};
    tms_h = {tms_h[62:0], tms_o};
  end
  always @(negedge tck_o) fall_total++;

  logic [MAXC-1:0] cap_run = '0;
  int              len_run = 1;
  int              fall_base = 0;
  int              tdo_idx;
  always_comb begin
    tdo_idx = len_run - 1 - (fall_total - fall_base);
    tdo_i   = (tdo_idx >= 0 && tdo_idx < MAXC) ? cap_run[tdo_idx] : 1'b0;
  end

  int done_total = 0, err_total = 0, done_rises = 0, ready_bad = 0;
  always @(negedge clk) begin
    if (done_o) begin done_total++; done_rises = rise_total; end
    if (err_o) err_total++;
    if (opnd_ready_o && tck_o) ready_bad++;
  end

  logic [7:0]      newb [4];
  logic [7:0]      expb [4];
  logic [7:0]      maskb[4];
  logic [MAXC-1:0] cap_v;
  logic [31:0]     rs = 32'h1ACE_B00C;
  bit              mm_at_start;
  logic [63:0]     last_chain;

  function automatic logic [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic run_shift(input int len, input bit cmp, input int stall, input bit poke);
    int rb, db, eb, nb;
    logic [63:0] lmask, exp_chain;
    bit exp_mm;
    string mtag;
    @(negedge clk);
    rb = rise_total; db = done_total; eb = err_total;
    fall_base = fall_total; len_run = len; cap_run = cap_v;
    start_i = 1'b1; cmp_en_i = cmp; len_m1_i = LW'(len - 1);
    @(negedge clk);
    start_i = 1'b0;
    mm_at_start = mismatch_o;
    nb = (len + 7) / 8;
    for (int j = 0; j < nb; j++) begin
      while (!opnd_ready_o) @(negedge clk);
      repeat (stall) @(negedge clk);
      opnd_new_i = newb[j]; opnd_exp_i = expb[j]; opnd_mask_i = maskb[j];
      opnd_valid_i = 1'b1;
      @(negedge clk);
      opnd_valid_i = 1'b0;
      if (poke && j == 0) begin
        start_i = 1'b1; len_m1_i = '0; cmp_en_i = ~cmp;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    while (done_total == db) @(negedge clk);
    @(negedge clk);
    lmask = (64'd1 << len) - 64'd1;
    exp_chain = '0; exp_mm = 1'b0;
    for (int i = 0; i < len; i++) begin
      exp_chain[len-1-i] = newb[i/8][i%8];
      if (cmp && maskb[i/8][i%8] && (cap_v[len-1-i] != expb[i/8][i%8])) exp_mm = 1'b1;
    end
    last_chain = tin_h & lmask;
    mtag = cmp ? "R6 masked compare" : "R7 ignore mode";
    chk(mm_at_start == 1'b0, "R9 cleared after start", mm_at_start, 0);
    chk(rise_total - rb == len, poke ? "R10 ignored start, tck rises" : "R2 tck rises",
        rise_total - rb, len);
    chk((tms_h & lmask) == 64'd1, "R3 tms pattern", tms_h & lmask, 1);
    chk(last_chain == exp_chain, "R4 chain contents", last_chain, exp_chain);
    chk(mismatch_o == exp_mm, mtag, mismatch_o, exp_mm);
    chk(done_total - db == 1 && done_rises - rb == len, "R8 done pulse",
        done_total - db, 1);
    chk(err_total - eb == int'(exp_mm), "R8 err strobe", err_total - eb, exp_mm);
    chk(busy_o == 1'b0, "R8 idle after done", busy_o, 0);
    chk(ready_bad == 0, "R5 ready only with tck low", ready_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tck_o, tms_o, busy_o, done_o, err_o, mismatch_o, opnd_ready_o} == 7'b0,
        "R1 reset state", {tck_o, tms_o, busy_o, done_o, err_o, mismatch_o, opnd_ready_o}, 0);

    // 16-cell example: two groups, upper nibble of each mask checked
    newb[0] = 8'h55; expb[0] = 8'h30; maskb[0] = 8'hF0;
    newb[1] = 8'h00; expb[1] = 8'h50; maskb[1] = 8'hF0;
    cap_v = 32'h0000_FCFA;
    run_shift(16, 1'b1, 0, 1'b0);
    chk(last_chain[15:0] == 16'hAA00, "R4 example load", last_chain[15:0], 16'hAA00);
    cap_v = 32'h0000_FCDA;          // unmasked cell 5 differs
    run_shift(16, 1'b1, 1, 1'b0);
    chk(mismatch_o == 1'b0, "R6 don't-care cell", mismatch_o, 0);
    cap_v = 32'h0000_F8FA;          // masked cell 10 differs
    run_shift(16, 1'b1, 2, 1'b0);
    chk(mismatch_o == 1'b1, "R6 masked cell differs", mismatch_o, 1);
    repeat (5) @(negedge clk);
    chk(mismatch_o == 1'b1, "R9 sticky after done", mismatch_o, 1);
    // ignore mode with every cell wrong
    maskb[0] = 8'hFF; maskb[1] = 8'hFF; expb[0] = 8'h00; expb[1] = 8'h00;
    cap_v = 32'hFFFF_FFFF;
    run_shift(16, 1'b0, 0, 1'b0);
    chk(mismatch_o == 1'b0, "R7 all cells wrong, ignored", mismatch_o, 0);

    // sweep every length in both modes
    for (int len = 1; len <= MAXC; len++) begin
      for (int m = 0; m < 2; m++) begin
        cap_v = rnd();
        for (int j = 0; j < 4; j++) begin
          newb[j] = rnd() & 8'hFF; maskb[j] = rnd() & 8'hFF; expb[j] = rnd() & 8'hFF;
        end
        if (m == 1) begin
          for (int i = 0; i < len; i++) expb[i/8][i%8] = cap_v[len-1-i];
          if (rnd() & 1) begin
            int fi;
            fi = int'(rnd() % len);
            expb[fi/8][fi%8] = ~expb[fi/8][fi%8];
          end
        end
        run_shift(len, m[0], int'(rnd() % 4), (len % 5) == 0);
      end
    end

    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

endmodule